// File: doc/BRIEF.md
# Dual-Bank Colour Matrix Converter

This block sits in a pixel pipeline and maps each three-component pixel through a 3x4 affine matrix. It turns RGB into YCbCr, YCbCr into RGB, or applies any other linear mix with an offset. Every output component is a weighted sum of the three input components plus a constant. The sum is rounded and clamped to the legal pixel range.

The programmable coefficients live in two banks. Software always loads the bank that is not in use, writes the mode code that selects it, and the switch takes effect on the next frame-start pulse. A frame is therefore never processed with a half-written matrix or a mix of two matrices. The mode can also select a pass-through path or one of two hardwired studio-range RGB-to-YCbCr matrices. Pixels enter and leave over valid/ready streams through a fixed three-stage pipeline.

Top module: `ccm_dualbank`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, the active mode is pass-through (code 0), and every bank coefficient is 0.
- R2: Register address 0 is the control register, with the mode in bits [2:0]. Addresses 1..6 hold bank A and addresses 7..12 hold bank B. Each address holds one pair of coefficients, and the pairs follow the row order (C11,C12), (C13,C14), (C21,C22), (C23,C24), (C31,C32), (C33,C34). The first coefficient of a pair is in bits [15:0] and the second is in bits [31:16].
- R3: The mode codes are 0 for pass-through, 2 for hardwired BT.601, 3 for hardwired BT.709, 4 for bank A and 5 for bank B. A control write carrying any other code is ignored, and the pending mode stays as it was.
- R4: A legal control write only updates the pending mode. The active mode takes the pending value on a cycle where `frame_start` is 1. Pixels accepted before that edge still use the previous mode.
- R5: A register write to the bank that the active mode selects (bank A in mode 4, bank B in mode 5) is ignored. Writes to the other bank always take effect.
- R6: Pixel components are 12-bit unsigned values in 8.4 format. Component j sits at `in_data[12j+11:12j]`, and output k sits at the same position in `out_data`. Columns 1..3 of the matrix are S2.13 coefficients, and column 4 is an S0.13 fraction of full scale. The block computes out_k = clamp(floor((sum_j Ckj*x_j + Ck4*4096 + 4096) / 8192), 0, 4095).
- R7: Mode 2 uses the rows (2104,4130,802,512), (-1214,-2384,3598,4096) and (3598,-3013,-585,4096). Mode 3 uses the rows (1496,5032,508,512), (-824,-2774,3598,4096) and (3598,-3268,-330,4096). Both map inputs R,G,B to outputs Y,Cb,Cr.
- R8: In mode 0 the output equals the input unchanged.
- R9: Every pixel leaves three clock cycles after it is accepted, in every mode, as long as `out_ready` stays high. The block accepts one pixel on every clock.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds steady and `in_ready` is 0. No pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse that applies the pending mode |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_data | input | 36 | Three 12-bit input components |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can accept a pixel |
| out_data | output | 36 | Three 12-bit output components |

## Verification
The bench sends white, black and saturated-primary pixels through both hardwired matrices. This separates the per-row gains from the offsets, and it separates the 601 weights from the 709 weights. It then uses custom bank matrices:
- A channel swap shows where each coefficient is packed in the registers.
- A gain of 2 drives the top clamp.
- Negative gains drive the bottom clamp.
- Halving odd values exposes the round-half-up rule.

Writes to the active bank, illegal mode codes and mode writes that have no frame pulse yet must each leave the output unchanged. A stalled burst shows that the output holds while the downstream is not ready and that the pixels keep their order.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

  typedef enum logic [2:0] {
    CCM_BYPASS = 3'd0,
    CCM_BT601  = 3'd2,
    CCM_BT709  = 3'd3,
    CCM_BANK_A = 3'd4,
    CCM_BANK_B = 3'd5
  } ccm_mode_e;

  localparam int CCM_ROWS  = 3;
  localparam int CCM_COLS  = 4;
  localparam int CCM_NCOEF = CCM_ROWS * CCM_COLS;
  localparam int CCM_NPAIR = CCM_NCOEF / 2;

  function automatic logic mode_legal(input logic [2:0] m);
    return (m == CCM_BYPASS) || (m == CCM_BT601) || (m == CCM_BT709) ||
           (m == CCM_BANK_A) || (m == CCM_BANK_B);
  endfunction

  // Hardwired studio-range RGB -> YCbCr matrices, S2.13, row-major.
  function automatic logic signed [15:0] builtin_coef(input logic use709, input int idx);
    logic signed [15:0] c;
    if (!use709) begin
      case (idx)
        0: c = 16'sd2104;   1: c = 16'sd4130;   2: c = 16'sd802;    3: c = 16'sd512;
        4: c = -16'sd1214;  5: c = -16'sd2384;  6: c = 16'sd3598;   7: c = 16'sd4096;
        8: c = 16'sd3598;   9: c = -16'sd3013;  10: c = -16'sd585;  11: c = 16'sd4096;
        default: c = '0;
      endcase
    end else begin
      case (idx)
        0: c = 16'sd1496;   1: c = 16'sd5032;   2: c = 16'sd508;    3: c = 16'sd512;
        4: c = -16'sd824;   5: c = -16'sd2774;  6: c = 16'sd3598;   7: c = 16'sd4096;
        8: c = 16'sd3598;   9: c = -16'sd3268;  10: c = -16'sd330;  11: c = 16'sd4096;
        default: c = '0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/ccm_coef_regs.sv
module ccm_coef_regs
  import ccm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int RAW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [RAW-1:0]          wr_addr,
  input  logic [2*CW-1:0]         wr_data,
  input  logic                    frame_start,
  output logic [2:0]              act_mode,
  output logic [CCM_NCOEF*CW-1:0] bank_a,
  output logic [CCM_NCOEF*CW-1:0] bank_b
);

  localparam int PAIR_W = 2 * CW;
  localparam int BASE_A = 1;
  localparam int BASE_B = BASE_A + CCM_NPAIR;

  logic [2:0] pend_mode;
  wire        ctl_hit = wr_en && (wr_addr == RAW'(0));

  // Named events for the checks below.
  wire hit_a   = wr_en && (wr_addr >= RAW'(BASE_A)) && (wr_addr < RAW'(BASE_B));
  wire hit_b   = wr_en && (wr_addr >= RAW'(BASE_B)) && (wr_addr < RAW'(BASE_B + CCM_NPAIR));
  wire lock_a  = (act_mode == CCM_BANK_A);
  wire lock_b  = (act_mode == CCM_BANK_B);
  wire blk_a   = hit_a && lock_a;
  wire blk_b   = hit_b && lock_b;

  wire [CCM_NCOEF*CW-1:0] flat [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    wire locked = (b == 0) ? lock_a : lock_b;
    for (genvar p = 0; p < CCM_NPAIR; p++) begin : g_pair
      logic [PAIR_W-1:0] pair_q;
      wire pair_hit = wr_en && (wr_addr == RAW'(BASE_A + b * CCM_NPAIR + p));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pair_q <= '0;
        else if (pair_hit && !locked) pair_q <= wr_data;
      end
      assign flat[b][p*PAIR_W +: PAIR_W] = pair_q;
    end
  end

  assign bank_a = flat[0];
  assign bank_b = flat[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mode <= CCM_BYPASS;
      act_mode  <= CCM_BYPASS;
    end else begin
      if (ctl_hit && mode_legal(wr_data[2:0])) pend_mode <= wr_data[2:0];
      if (frame_start)                         act_mode  <= pend_mode;
    end
  end

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_mode));

  // R3
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_legal(act_mode) && mode_legal(pend_mode));

  // R5
  lock_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_a |=> $stable(bank_a));

  // R5
  lock_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_b |=> $stable(bank_b));

endmodule

// File: rtl/ccm_coef_mux.sv
module ccm_coef_mux
  import ccm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [2:0]              act_mode,
  input  logic [CCM_NCOEF*CW-1:0] bank_a,
  input  logic [CCM_NCOEF*CW-1:0] bank_b,
  output logic [CCM_NCOEF*CW-1:0] coef,
  output logic                    bypass
);

  localparam int SHIFT = CW - 16;

  function automatic logic [CW-1:0] widen(input logic signed [15:0] c);
    logic signed [CW-1:0] e;
    e = CW'(c);
    return e <<< SHIFT;
  endfunction

  always_comb begin
    bypass = (act_mode == CCM_BYPASS);
    coef   = '0;
    for (int i = 0; i < CCM_NCOEF; i++) begin
      case (act_mode)
        CCM_BT601:  coef[i*CW +: CW] = widen(builtin_coef(1'b0, i));
        CCM_BT709:  coef[i*CW +: CW] = widen(builtin_coef(1'b1, i));
        CCM_BANK_A: coef[i*CW +: CW] = bank_a[i*CW +: CW];
        CCM_BANK_B: coef[i*CW +: CW] = bank_b[i*CW +: CW];
        default:    coef[i*CW +: CW] = '0;
      endcase
    end
  end

endmodule

// File: rtl/ccm_mac_pipe.sv
module ccm_mac_pipe
  import ccm_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CCM_ROWS*DW-1:0]  in_data,
  input  logic [CCM_NCOEF*CW-1:0] coef,
  input  logic                    bypass,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [CCM_ROWS*DW-1:0]  out_data
);

  localparam int CFRAC = CW - 3;
  localparam int PW    = CW + DW + 1;
  localparam int AW    = PW + 2;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CFRAC - 1);
  localparam logic signed [AW-1:0] TOP  = AW'((1 << DW) - 1);

  function automatic logic signed [PW-1:0] mul_cx(input logic [CW-1:0] c, input logic [DW-1:0] x);
    logic signed [PW-1:0] cs, xs;
    cs = PW'($signed(c));
    xs = PW'($signed({1'b0, x}));
    return cs * xs;
  endfunction

  function automatic logic signed [AW-1:0] off_term(input logic [CW-1:0] c);
    logic signed [AW-1:0] e;
    e = AW'($signed(c));
    return e <<< DW;
  endfunction

  function automatic logic [DW-1:0] round_clamp(input logic signed [AW-1:0] acc);
    logic signed [AW-1:0] r;
    r = (acc + HALF) >>> CFRAC;
    if (r < 0)        return '0;
    else if (r > TOP) return '1;
    else              return r[DW-1:0];
  endfunction

  logic v1, v2, v3;
  logic signed [PW-1:0] prod_q [CCM_ROWS][CCM_ROWS];
  logic signed [AW-1:0] offs_q [CCM_ROWS];
  logic signed [AW-1:0] acc_q  [CCM_ROWS];
  logic                 byp1, byp2;
  logic [CCM_ROWS*DW-1:0] pix1, pix2, res_q;

  wire adv     = !v3 || out_ready;
  wire in_fire = in_valid && adv;

  assign in_ready  = adv;
  assign out_valid = v3;
  assign out_data  = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int k = 0; k < CCM_ROWS; k++) begin
        for (int j = 0; j < CCM_ROWS; j++)
          prod_q[k][j] <= mul_cx(coef[(k*CCM_COLS+j)*CW +: CW], in_data[j*DW +: DW]);
        offs_q[k] <= off_term(coef[(k*CCM_COLS+3)*CW +: CW]);
        acc_q[k]  <= AW'(prod_q[k][0]) + AW'(prod_q[k][1]) + AW'(prod_q[k][2]) + offs_q[k];
        res_q[k*DW +: DW] <= byp2 ? pix2[k*DW +: DW] : round_clamp(acc_q[k]);
      end
      byp1 <= bypass;
      pix1 <= in_data;
      byp2 <= byp1;
      pix2 <= pix1;
    end
  end

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> v1);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: rtl/ccm_dualbank.sv
module ccm_dualbank
  import ccm_pkg::*;
#(
  parameter int DW  = 12,
  parameter int CW  = 16,
  parameter int RAW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic [RAW-1:0]         reg_addr,
  input  logic [2*CW-1:0]        reg_wdata,
  input  logic                   frame_start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CCM_ROWS*DW-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [CCM_ROWS*DW-1:0] out_data
);

  logic [2:0]              act_mode;
  logic [CCM_NCOEF*CW-1:0] bank_a, bank_b, coef;
  logic                    bypass;

  ccm_coef_regs #(.CW(CW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .frame_start(frame_start), .act_mode(act_mode),
    .bank_a(bank_a), .bank_b(bank_b)
  );

  ccm_coef_mux #(.CW(CW)) u_mux (
    .act_mode(act_mode), .bank_a(bank_a), .bank_b(bank_b),
    .coef(coef), .bypass(bypass)
  );

  ccm_mac_pipe #(.DW(DW), .CW(CW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef(coef), .bypass(bypass), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

endmodule

// File: tb/ccm_dualbank_test.sv
`timescale 1ns/1ps
module ccm_dualbank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_data;

  always #2 clk = ~clk;

  ccm_dualbank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_push = 0;
  bit lat_on = 1'b1;
  bit done = 1'b0;

  logic [35:0] exp_q[$];
  string       tag_q[$];
  int          acc_q[$];

  // bench-side view of the block
  int ba[12], bb[12];
  int pend_m = 0, act_m = 0;
  int t601[12] = '{2104, 4130, 802, 512, -1214, -2384, 3598, 4096, 3598, -3013, -585, 4096};
  int t709[12] = '{1496, 5032, 508, 512, -824, -2774, 3598, 4096, 3598, -3268, -330, 4096};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [35:0] model(input logic [11:0] x0, input logic [11:0] x1, input logic [11:0] x2);
    int c[12];
    longint xs[3];
    logic [35:0] r;
    xs[0] = longint'(x0); xs[1] = longint'(x1); xs[2] = longint'(x2);
    case (act_m)
      2: c = t601;
      3: c = t709;
      4: c = ba;
      5: c = bb;
      default: return {x2, x1, x0};
    endcase
    for (int k = 0; k < 3; k++) begin
      longint s = 0;
      longint q;
      for (int j = 0; j < 3; j++) s += longint'(c[4*k+j]) * xs[j];
      s += longint'(c[4*k+3]) * 4096;
      q = (s + 4096) >>> 13;
      if (q < 0) q = 0;
      if (q > 4095) q = 4095;
      r[12*k +: 12] = q[11:0];
    end
    return r;
  endfunction

  task automatic reg_wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b0;
    reg_wr_en = 1'b1; reg_addr = addr[3:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (addr == 0) begin
      if (d[2:0] inside {3'd0, 3'd2, 3'd3, 3'd4, 3'd5}) pend_m = int'(d[2:0]);
    end else if (addr >= 1 && addr <= 6) begin
      if (act_m != 4) begin
        ba[2*(addr-1)]   = int'($signed(d[15:0]));
        ba[2*(addr-1)+1] = int'($signed(d[31:16]));
      end
    end else if (addr >= 7 && addr <= 12) begin
      if (act_m != 5) begin
        bb[2*(addr-7)]   = int'($signed(d[15:0]));
        bb[2*(addr-7)+1] = int'($signed(d[31:16]));
      end
    end
  endtask

  task automatic load_bank(input int base, input int c[12]);
    for (int p = 0; p < 6; p++) begin
      logic [15:0] lo, hi;
      lo = c[2*p][15:0];
      hi = c[2*p+1][15:0];
      reg_wr(base + p, {hi, lo});
    end
  endtask

  task automatic frame();
    @(negedge clk);
    in_valid = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    act_m = pend_m;
  endtask

  task automatic send(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = {c, b, a};
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(a, b, c));
    tag_q.push_back(tag);
    acc_q.push_back(cyc);
    last_push = cyc;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(1);
    while (exp_q.size() != 0) @(negedge clk);
    idle(1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 (extra output)", out_data, '0);
      end else begin
        logic [35:0] e;
        string t;
        int a;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = acc_q.pop_front();
        check(out_data === e, t, out_data, e);
        if (lat_on) check(cyc - a == 3, "R9 latency", 36'(cyc - a), 36'd3);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bankA1[12] = '{0, 8192, 0, 0, 4096, 4096, 0, 512, 16384, 0, 0, 0};
    int bankB1[12] = '{-8192, 0, 0, 4096, 0, -8192, 0, 0, 4096, 0, 0, 0};
    int bankA2[12] = '{0, 0, 8192, 0, 0, 8192, 0, 0, 8192, 0, 0, 0};
    logic [35:0] held;
    int s0;
    for (int i = 0; i < 12; i++) begin ba[i] = 0; bb[i] = 0; end

    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid", 36'(out_valid), 36'd0);
    check(in_ready == 1'b1, "R1 in_ready", 36'(in_ready), 36'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after release", 36'(out_valid), 36'd0);

    // R1 default pass-through, R8 pass-through path
    send(12'h123, 12'h456, 12'h789, "R1 default mode");
    send(12'hfff, 12'h000, 12'h800, "R8 bypass");
    send(12'h001, 12'hffe, 12'h7ff, "R8 bypass");
    drain();

    // R4: mode write without a frame pulse changes nothing
    reg_wr(0, 32'd2);
    send(12'h321, 12'h654, 12'h987, "R4 pending only");
    drain();
    frame();
    send(12'hfff, 12'hfff, 12'hfff, "R7 601 white");
    send(12'h000, 12'h000, 12'h000, "R7 601 black");
    send(12'hfff, 12'h000, 12'h000, "R7 601 red");
    send(12'h000, 12'h000, 12'hfff, "R7 601 blue");
    drain();
    reg_wr(0, 32'd3);
    frame();
    send(12'hfff, 12'hfff, 12'hfff, "R7 709 white");
    send(12'h000, 12'hfff, 12'h000, "R7 709 green");
    send(12'hfff, 12'h000, 12'h000, "R7 709 red");
    drain();

    // R3: illegal codes are ignored
    reg_wr(0, 32'd6);
    reg_wr(0, 32'd1);
    frame();
    send(12'h000, 12'hfff, 12'h000, "R3 illegal mode kept 709");
    drain();

    // R2/R6: bank A, packing, top clamp
    load_bank(1, bankA1);
    reg_wr(0, 32'd4);
    frame();
    send(12'd3000, 12'd1000, 12'd2000, "R6 bankA clamp high");
    send(12'd100, 12'd200, 12'd300, "R2 bankA packing");
    send(12'd4095, 12'd4095, 12'd0, "R6 bankA mix");
    drain();

    // R2/R6: bank B loaded while A active, bottom clamp and rounding
    load_bank(7, bankB1);
    reg_wr(0, 32'd5);
    frame();
    send(12'd3000, 12'd5, 12'd0, "R6 bankB clamp low");
    send(12'd1, 12'd0, 12'd0, "R6 round half up 0.5");
    send(12'd3, 12'd0, 12'd0, "R6 round half up 1.5");
    send(12'd2048, 12'd0, 12'd0, "R2 bankB packing");
    drain();

    // R5: writes to the active bank are ignored, the idle bank accepts
    load_bank(7, bankA1);
    send(12'd1000, 12'd0, 12'd7, "R5 active bank untouched");
    drain();
    load_bank(1, bankA2);
    reg_wr(0, 32'd4);
    frame();
    send(12'd10, 12'd20, 12'd30, "R5 idle bank written");
    drain();

    // R10: stall with a full pipeline
    lat_on = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    send(12'd1, 12'd2, 12'd3, "R10 order");
    send(12'd4, 12'd5, 12'd6, "R10 order");
    send(12'd7, 12'd8, 12'd9, "R10 order");
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    held = out_data;
    check(out_valid == 1'b1, "R10 valid held", 36'(out_valid), 36'd1);
    check(in_ready == 1'b0, "R10 in_ready low", 36'(in_ready), 36'd0);
    repeat (4) @(negedge clk);
    #1;
    check(out_data === held, "R10 data stable", out_data, held);
    check(out_valid == 1'b1, "R10 valid still held", 36'(out_valid), 36'd1);
    out_ready = 1'b1;
    drain();
    lat_on = 1'b1;

    // R9: one pixel per clock
    send(12'd11, 12'd12, 12'd13, "R9 stream");
    s0 = last_push;
    for (int i = 1; i < 8; i++) send(12'(i * 300), 12'(i * 100), 12'(4095 - i * 200), "R9 stream");
    check(last_push - s0 == 7, "R9 throughput", 36'(last_push - s0), 36'd7);
    drain();

    check(exp_q.size() == 0, "R10 no lost pixel", 36'(exp_q.size()), 36'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule